// File: doc/BRIEF.md
# DMA Multi-Block Chaining Sequencer

This block is the boundary controller for a single DMA channel that moves data as a chain of blocks. Software programs the first source, destination, next-descriptor pointer and control words, then pulses a start input. The beat-level mover runs while `mv_active` is high and reports the end of each block with a one-cycle `mv_done` pulse. The sequencer then decides what the next block looks like.

At each block boundary the source address can be put back to its first programmed value. While that reload mode is on, any source word found in a descriptor is thrown away. When the next-descriptor pointer is non-zero, a five-word descriptor is read from memory. It updates the destination, the pointer and both control words, and it updates the source only when reload is off. A block boundary can also halt the channel until software acknowledges the block-complete status.

The chain ends on its own when reload is off and the pointer is zero. The sequencer then raises transfer-complete and drops channel-enable, so software can either poll the enable or wait for the status bit. If software drops the enable, the transfer stops at once.

Top module: `dma_chain_seq`

## Requirements
- R1: After reset, `ch_en`, `blk_st`, `xfer_st`, `rd_valid` and `mv_active` are all 0.
- R2: A `sw_start` pulse while `ch_en` is 0 loads all programmed values. One cycle later `ch_en` and `mv_active` are 1 and the `cur_*` outputs show the programmed values. A `sw_start` while `ch_en` is 1 has no effect.
- R3: At a block end with `sw_reload`=1, `cur_src` returns to the value captured at start. Descriptor word 0 is discarded while `sw_reload`=1 and loaded into `cur_src` while `sw_reload`=0.
- R4: A descriptor fetch reads five words at pointer+0, +4, +8, +12 and +16, in ascending order. A word is taken on each cycle where both `rd_valid` and `rd_ready` are 1, and `rd_addr` holds while `rd_ready` is 0. Words 1 to 4 go, in that order, to destination, next pointer, control low and control high. `mv_active` rises on the cycle after word 4 is taken.
- R5: If `sw_int_en`=1 and `sw_blk_mask`=1 at a non-terminating block end, `blk_st` is 1 on the next cycle. The sequencer then stalls, with `mv_active` and `rd_valid` at 0, until `blk_st` is 0. It proceeds one cycle after `blk_st` first reads 0.
- R6: If `sw_int_en`=0 or `sw_blk_mask`=0, a block end leaves `blk_st` unchanged. The next step (fetch or next block) starts on the next cycle.
- R7: A block end with `sw_reload`=0 and `cur_next`=0 is terminating. On the next cycle `xfer_st`=1 and `ch_en`=0, and no read is issued.
- R8: A block end with `sw_reload`=1 and `cur_next`=0 starts another block at once, with no descriptor read.
- R9: A 1 on `sw_clr_blk` or `sw_clr_xfer` clears the matching status bit on the next cycle. A hardware set in the same cycle wins over the clear.
- R10: `sw_disable` while `ch_en`=1 returns the channel to idle on the next cycle from any state. `ch_en` and `rd_valid` go to 0, and `xfer_st` is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_start | input | 1 | Start pulse, accepted only when idle |
| sw_src | input | WIDTH | Initial source address |
| sw_dst | input | WIDTH | Initial destination address |
| sw_next | input | WIDTH | Initial next-descriptor pointer (0 = none) |
| sw_ctl_lo | input | WIDTH | Initial control word, low half |
| sw_ctl_hi | input | WIDTH | Initial control word, high half |
| sw_reload | input | 1 | Source reload mode |
| sw_int_en | input | 1 | Channel interrupt enable |
| sw_blk_mask | input | 1 | Block-complete unmask (1 = unmasked) |
| sw_clr_blk | input | 1 | Write-1 clear of block-complete status |
| sw_clr_xfer | input | 1 | Write-1 clear of transfer-complete status |
| sw_disable | input | 1 | Software clear of channel enable (abort) |
| mv_active | output | 1 | Block in progress, mover may run |
| mv_done | input | 1 | Mover reports block finished |
| rd_valid | output | 1 | Descriptor read request |
| rd_addr | output | WIDTH | Descriptor read byte address |
| rd_ready | input | 1 | Read accepted, `rd_data` valid this cycle |
| rd_data | input | WIDTH | Descriptor read data |
| ch_en | output | 1 | Channel enable |
| blk_st | output | 1 | Block-complete status |
| xfer_st | output | 1 | Transfer-complete status |
| cur_src | output | WIDTH | Current source address |
| cur_dst | output | WIDTH | Current destination address |
| cur_next | output | WIDTH | Current next-descriptor pointer |
| cur_ctl_lo | output | WIDTH | Current control word, low half |
| cur_ctl_hi | output | WIDTH | Current control word, high half |

## Verification
The properties assume that `mv_done` is pulsed only while `mv_active` is high. They also assume that `rd_data` is valid in any cycle where `rd_ready` is high, and that the mode inputs (`sw_reload`, `sw_int_en`, `sw_blk_mask`) are steady around a block end. The stimulus gives a single-cycle `mv_done` only after it has seen `mv_active` high. It changes mode inputs only on falling edges, away from the block-end cycle. Its memory model returns data computed from `rd_addr` in the same cycle, so every accepted read carries consistent data.

// File: rtl/dmaseq_pkg.sv
`timescale 1ns/1ps
package dmaseq_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_RUN   = 2'd1,
        SQ_STALL = 2'd2,
        SQ_FETCH = 2'd3
    } sq_state_e;

    // descriptor word slots, ascending address order
    localparam int unsigned DESC_WORDS = 5;
    localparam int unsigned WD_SRC     = 0;
    localparam int unsigned WD_DST     = 1;
    localparam int unsigned WD_NEXT    = 2;
    localparam int unsigned WD_CLO     = 3;
    localparam int unsigned WD_CHI     = 4;

endpackage

// File: rtl/dmaseq_fetch.sv
`timescale 1ns/1ps
module dmaseq_fetch #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned NWORDS = 5,
    parameter int unsigned IW     = $clog2(NWORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic             abort,
    input  logic [WIDTH-1:0] base,
    input  logic             rd_ready,
    output logic             rd_valid,
    output logic [WIDTH-1:0] rd_addr,
    output logic             take,
    output logic [IW-1:0]    idx,
    output logic             last_take
);
    localparam int unsigned STRIDE = WIDTH / 8;

    typedef struct packed {
        logic             busy;
        logic [IW-1:0]    idx;
        logic [WIDTH-1:0] base;
    } fetch_t;

    fetch_t f_d, f_q;

    always_comb begin
        f_d       = f_q;
        take      = f_q.busy & rd_ready;
        last_take = take && (f_q.idx == IW'(NWORDS - 1));
        if (abort) begin
            f_d.busy = 1'b0;
            f_d.idx  = '0;
        end else if (go) begin
            f_d.busy = 1'b1;
            f_d.idx  = '0;
            f_d.base = base;
        end else if (take) begin
            if (last_take) begin
                f_d.busy = 1'b0;
                f_d.idx  = '0;
            end else begin
                f_d.idx = f_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign rd_valid = f_q.busy;
    assign rd_addr  = f_q.base + WIDTH'(f_q.idx) * WIDTH'(STRIDE);
    assign idx      = f_q.idx;

endmodule

// File: rtl/dmaseq_irq.sv
`timescale 1ns/1ps
module dmaseq_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic set_blk,
    input  logic set_xfer,
    input  logic clr_blk,
    input  logic clr_xfer,
    output logic blk_st,
    output logic xfer_st
);
    typedef struct packed {
        logic blk;
        logic xfer;
    } irq_t;

    irq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        // hardware set takes priority over a same-cycle clear
        if (set_blk)       s_d.blk = 1'b1;
        else if (clr_blk)  s_d.blk = 1'b0;
        if (set_xfer)      s_d.xfer = 1'b1;
        else if (clr_xfer) s_d.xfer = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign blk_st  = s_q.blk;
    assign xfer_st = s_q.xfer;

endmodule

// File: rtl/dma_chain_seq.sv
`timescale 1ns/1ps
module dma_chain_seq
    import dmaseq_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_start,
    input  logic [WIDTH-1:0] sw_src,
    input  logic [WIDTH-1:0] sw_dst,
    input  logic [WIDTH-1:0] sw_next,
    input  logic [WIDTH-1:0] sw_ctl_lo,
    input  logic [WIDTH-1:0] sw_ctl_hi,
    input  logic             sw_reload,
    input  logic             sw_int_en,
    input  logic             sw_blk_mask,
    input  logic             sw_clr_blk,
    input  logic             sw_clr_xfer,
    input  logic             sw_disable,
    output logic             mv_active,
    input  logic             mv_done,
    output logic             rd_valid,
    output logic [WIDTH-1:0] rd_addr,
    input  logic             rd_ready,
    input  logic [WIDTH-1:0] rd_data,
    output logic             ch_en,
    output logic             blk_st,
    output logic             xfer_st,
    output logic [WIDTH-1:0] cur_src,
    output logic [WIDTH-1:0] cur_dst,
    output logic [WIDTH-1:0] cur_next,
    output logic [WIDTH-1:0] cur_ctl_lo,
    output logic [WIDTH-1:0] cur_ctl_hi
);
    localparam int unsigned IW = $clog2(DESC_WORDS);

    typedef struct packed {
        sq_state_e        st;
        logic             en;
        logic [WIDTH-1:0] src;
        logic [WIDTH-1:0] src_init;
        logic [WIDTH-1:0] dst;
        logic [WIDTH-1:0] nxt;
        logic [WIDTH-1:0] clo;
        logic [WIDTH-1:0] chi;
    } ctx_t;

    ctx_t c_d, c_q;

    logic          set_blk, set_xfer;
    logic          fetch_go, fetch_abort;
    logic          f_take, f_last;
    logic [IW-1:0] f_idx;
    logic          term_end, has_next, want_stall;

    dmaseq_fetch #(
        .WIDTH (WIDTH),
        .NWORDS(DESC_WORDS),
        .IW    (IW)
    ) u_fetch (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (fetch_go),
        .abort    (fetch_abort),
        .base     (c_q.nxt),
        .rd_ready (rd_ready),
        .rd_valid (rd_valid),
        .rd_addr  (rd_addr),
        .take     (f_take),
        .idx      (f_idx),
        .last_take(f_last)
    );

    dmaseq_irq u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_blk (set_blk),
        .set_xfer(set_xfer),
        .clr_blk (sw_clr_blk),
        .clr_xfer(sw_clr_xfer),
        .blk_st  (blk_st),
        .xfer_st (xfer_st)
    );

    always_comb begin
        c_d         = c_q;
        set_blk     = 1'b0;
        set_xfer    = 1'b0;
        fetch_go    = 1'b0;
        fetch_abort = 1'b0;
        has_next    = (c_q.nxt != '0);
        term_end    = !sw_reload && !has_next;
        want_stall  = sw_int_en && sw_blk_mask;

        unique case (c_q.st)
            SQ_IDLE: begin
                if (sw_start) begin
                    c_d.st       = SQ_RUN;
                    c_d.en       = 1'b1;
                    c_d.src      = sw_src;
                    c_d.src_init = sw_src;
                    c_d.dst      = sw_dst;
                    c_d.nxt      = sw_next;
                    c_d.clo      = sw_ctl_lo;
                    c_d.chi      = sw_ctl_hi;
                end
            end
            SQ_RUN: begin
                if (sw_disable) begin
                    c_d.st = SQ_IDLE;
                    c_d.en = 1'b0;
                end else if (mv_done) begin
                    if (term_end) begin
                        set_xfer = 1'b1;
                        c_d.en   = 1'b0;
                        c_d.st   = SQ_IDLE;
                    end else begin
                        if (sw_reload) c_d.src = c_q.src_init;
                        if (want_stall) begin
                            set_blk = 1'b1;
                            c_d.st  = SQ_STALL;
                        end else if (has_next) begin
                            fetch_go = 1'b1;
                            c_d.st   = SQ_FETCH;
                        end else begin
                            c_d.st = SQ_RUN;
                        end
                    end
                end
            end
            SQ_STALL: begin
                if (sw_disable) begin
                    c_d.st = SQ_IDLE;
                    c_d.en = 1'b0;
                end else if (!blk_st) begin
                    if (has_next) begin
                        fetch_go = 1'b1;
                        c_d.st   = SQ_FETCH;
                    end else begin
                        c_d.st = SQ_RUN;
                    end
                end
            end
            SQ_FETCH: begin
                if (sw_disable) begin
                    fetch_abort = 1'b1;
                    c_d.st      = SQ_IDLE;
                    c_d.en      = 1'b0;
                end else if (f_take) begin
                    if (f_idx == IW'(WD_SRC)) begin
                        if (!sw_reload) c_d.src = rd_data;
                    end else if (f_idx == IW'(WD_DST)) begin
                        c_d.dst = rd_data;
                    end else if (f_idx == IW'(WD_NEXT)) begin
                        c_d.nxt = rd_data;
                    end else if (f_idx == IW'(WD_CLO)) begin
                        c_d.clo = rd_data;
                    end else begin
                        c_d.chi = rd_data;
                    end
                    if (f_last) c_d.st = SQ_RUN;
                end
            end
            default: c_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q    <= '0;
            c_q.st <= SQ_IDLE;
        end else begin
            c_q <= c_d;
        end
    end

    assign mv_active  = (c_q.st == SQ_RUN);
    assign ch_en      = c_q.en;
    assign cur_src    = c_q.src;
    assign cur_dst    = c_q.dst;
    assign cur_next   = c_q.nxt;
    assign cur_ctl_lo = c_q.clo;
    assign cur_ctl_hi = c_q.chi;

endmodule

// File: rtl/dma_chain_seq_chk.sv
`timescale 1ns/1ps
module dma_chain_seq_chk #(
    parameter int unsigned WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sw_start,
    input logic             sw_reload,
    input logic             sw_int_en,
    input logic             sw_blk_mask,
    input logic             sw_disable,
    input logic             mv_done,
    input logic             mv_active,
    input logic             rd_valid,
    input logic             rd_ready,
    input logic [WIDTH-1:0] rd_addr,
    input logic             ch_en,
    input logic             blk_st,
    input logic             xfer_st,
    input logic [WIDTH-1:0] cur_src,
    input logic [WIDTH-1:0] cur_dst,
    input logic [WIDTH-1:0] cur_next
);

    a_r2_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_start && mv_active && !mv_done && !sw_disable)
        |=> ($stable(cur_src) && $stable(cur_dst) && ch_en));

    a_r4_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready && !sw_disable)
        |=> (rd_valid && $stable(rd_addr)));

    a_r5_stall_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (mv_active && mv_done && !sw_disable && sw_int_en && sw_blk_mask
         && (sw_reload || cur_next != '0))
        |=> (blk_st && !mv_active && !rd_valid));

    a_r7_terminate: assert property (@(posedge clk) disable iff (!rst_n)
        (mv_active && mv_done && !sw_disable && !sw_reload && cur_next == '0)
        |=> (xfer_st && !ch_en && !rd_valid));

    a_r10_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_en && sw_disable)
        |=> (!ch_en && !rd_valid && !mv_active));

    a_r10_no_xfer_on_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_en && sw_disable && !xfer_st)
        |=> !xfer_st);

endmodule

bind dma_chain_seq dma_chain_seq_chk #(.WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sw_start   (sw_start),
    .sw_reload  (sw_reload),
    .sw_int_en  (sw_int_en),
    .sw_blk_mask(sw_blk_mask),
    .sw_disable (sw_disable),
    .mv_done    (mv_done),
    .mv_active  (mv_active),
    .rd_valid   (rd_valid),
    .rd_ready   (rd_ready),
    .rd_addr    (rd_addr),
    .ch_en      (ch_en),
    .blk_st     (blk_st),
    .xfer_st    (xfer_st),
    .cur_src    (cur_src),
    .cur_dst    (cur_dst),
    .cur_next   (cur_next)
);

// File: tb/sim_dma_chain_seq.sv
`timescale 1ns/1ps
module sim_dma_chain_seq;
    localparam int unsigned W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sw_start = 1'b0;
    logic [W-1:0] sw_src = '0, sw_dst = '0, sw_next = '0, sw_ctl_lo = '0, sw_ctl_hi = '0;
    logic         sw_reload = 1'b0, sw_int_en = 1'b0, sw_blk_mask = 1'b0;
    logic         sw_clr_blk = 1'b0, sw_clr_xfer = 1'b0, sw_disable = 1'b0;
    logic         mv_active, mv_done = 1'b0;
    logic         rd_valid, rd_ready = 1'b0;
    logic [W-1:0] rd_addr, rd_data;
    logic         ch_en, blk_st, xfer_st;
    logic [W-1:0] cur_src, cur_dst, cur_next, cur_ctl_lo, cur_ctl_hi;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    dma_chain_seq #(.WIDTH(W)) u0 (
        .clk(clk), .rst_n(rst_n), .sw_start(sw_start), .sw_src(sw_src), .sw_dst(sw_dst),
        .sw_next(sw_next), .sw_ctl_lo(sw_ctl_lo), .sw_ctl_hi(sw_ctl_hi),
        .sw_reload(sw_reload), .sw_int_en(sw_int_en), .sw_blk_mask(sw_blk_mask),
        .sw_clr_blk(sw_clr_blk), .sw_clr_xfer(sw_clr_xfer), .sw_disable(sw_disable),
        .mv_active(mv_active), .mv_done(mv_done), .rd_valid(rd_valid), .rd_addr(rd_addr),
        .rd_ready(rd_ready), .rd_data(rd_data), .ch_en(ch_en), .blk_st(blk_st),
        .xfer_st(xfer_st), .cur_src(cur_src), .cur_dst(cur_dst), .cur_next(cur_next),
        .cur_ctl_lo(cur_ctl_lo), .cur_ctl_hi(cur_ctl_hi)
    );

    // descriptor memory: pages at 0x100 and 0x200; the first links to the second
    function automatic logic [31:0] mem_word(input logic [31:0] a);
        logic [31:0] pg;
        pg = {28'd0, a[11:8]};
        case (a[4:2])
            3'd0: return 32'h5000_0000 | pg;
            3'd1: return 32'hD000_0000 | pg;
            3'd2: return (pg == 32'd1) ? 32'h0000_0200 : 32'h0;
            3'd3: return 32'hC000_0000 | pg;
            3'd4: return 32'hE000_0000 | pg;
            default: return 32'hDEAD_0000;
        endcase
    endfunction

    assign rd_data = mem_word(rd_addr);

    // {reload, int_en, mask, next!=0, exp_stall, exp_fetch, exp_done}
    localparam logic [6:0] ROWS [0:7] = '{
        7'b1111100, 7'b1011010, 7'b1101010, 7'b0110001,
        7'b1110100, 7'b1000000, 7'b0001010, 7'b0111100
    };

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic start_xfer(input logic [31:0] src, input logic [31:0] nxt);
        sw_src = src; sw_dst = 32'h11; sw_next = nxt; sw_ctl_lo = 32'h22; sw_ctl_hi = 32'h33;
        sw_start = 1'b1;
        step();
        sw_start = 1'b0;
    endtask

    task automatic block_end();
        mv_done = 1'b1;
        step();
        mv_done = 1'b0;
    endtask

    task automatic cleanup();
        sw_disable = 1'b1; sw_clr_blk = 1'b1; sw_clr_xfer = 1'b1;
        step();
        sw_disable = 1'b0; sw_clr_blk = 1'b0; sw_clr_xfer = 1'b0;
    endtask

    task automatic take_five(input logic [31:0] base);
        for (int k = 0; k < 5; k++) begin
            chk("R4", "rd_valid during fetch", rd_valid, 1'b1);
            chk("R4", "ascending rd_addr", rd_addr, base + 32'(4 * k));
            step();
        end
        chk("R4", "rd_valid after word 4", rd_valid, 1'b0);
        chk("R4", "mv_active after word 4", mv_active, 1'b1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        step(); step();
        chk("R1", "ch_en in reset", ch_en, 1'b0);
        rst_n = 1'b1;
        step();
        chk("R1", "ch_en", ch_en, 1'b0);
        chk("R1", "blk_st", blk_st, 1'b0);
        chk("R1", "xfer_st", xfer_st, 1'b0);
        chk("R1", "rd_valid", rd_valid, 1'b0);
        chk("R1", "mv_active", mv_active, 1'b0);

        // table walk: one block end per mode combination
        for (int i = 0; i < 8; i++) begin
            sw_reload = ROWS[i][6]; sw_int_en = ROWS[i][5]; sw_blk_mask = ROWS[i][4];
            rd_ready = 1'b0;
            start_xfer(32'h1000 + 32'(i), ROWS[i][3] ? 32'h100 : 32'h0);
            chk("R2", "ch_en after start", ch_en, 1'b1);
            chk("R2", "mv_active after start", mv_active, 1'b1);
            block_end();
            chk("R5", "blk_st after block end", blk_st, ROWS[i][2]);
            chk("R6", "rd_valid after block end", rd_valid, ROWS[i][1]);
            chk("R7", "xfer_st after block end", xfer_st, ROWS[i][0]);
            chk("R7", "ch_en after block end", ch_en, !ROWS[i][0]);
            chk("R8", "mv_active after block end", mv_active, !(ROWS[i][2] | ROWS[i][1] | ROWS[i][0]));
            chk("R3", "cur_src after block end", cur_src, 32'h1000 + 32'(i));
            cleanup();
            chk("R10", "ch_en after abort", ch_en, 1'b0);
            chk("R10", "rd_valid after abort", rd_valid, 1'b0);
            chk("R9", "statuses cleared", {30'd0, blk_st, xfer_st}, 32'd0);
        end

        // reload chain with stalls
        sw_reload = 1'b1; sw_int_en = 1'b1; sw_blk_mask = 1'b1; rd_ready = 1'b0;
        start_xfer(32'hAAAA_0000, 32'h100);
        chk("R2", "cur_src loaded", cur_src, 32'hAAAA_0000);
        chk("R2", "cur_next loaded", cur_next, 32'h100);
        chk("R2", "cur_ctl_hi loaded", cur_ctl_hi, 32'h33);
        sw_src = 32'hBBBB_0000; sw_start = 1'b1;
        step();
        sw_start = 1'b0;
        chk("R2", "start while enabled ignored", cur_src, 32'hAAAA_0000);
        block_end();
        chk("R5", "blk_st set", blk_st, 1'b1);
        step(); step(); step();
        chk("R5", "still stalled blk_st", blk_st, 1'b1);
        chk("R5", "no read while stalled", rd_valid, 1'b0);
        chk("R5", "no block while stalled", mv_active, 1'b0);
        sw_clr_blk = 1'b1;
        step();
        sw_clr_blk = 1'b0;
        chk("R9", "blk_st cleared", blk_st, 1'b0);
        chk("R5", "release waits one cycle", rd_valid, 1'b0);
        step();
        chk("R5", "fetch after release", rd_valid, 1'b1);
        step();
        chk("R4", "rd_addr held without ready", rd_addr, 32'h100);
        rd_ready = 1'b1;
        take_five(32'h100);
        chk("R3", "word 0 discarded in reload", cur_src, 32'hAAAA_0000);
        chk("R4", "dst from word 1", cur_dst, 32'hD000_0001);
        chk("R4", "next from word 2", cur_next, 32'h200);
        chk("R4", "ctl_lo from word 3", cur_ctl_lo, 32'hC000_0001);
        chk("R4", "ctl_hi from word 4", cur_ctl_hi, 32'hE000_0001);
        block_end();
        sw_clr_blk = 1'b1;
        step();
        sw_clr_blk = 1'b0;
        step();
        take_five(32'h200);
        chk("R4", "next zero from second descriptor", cur_next, 32'h0);
        sw_reload = 1'b0;
        block_end();
        chk("R7", "xfer_st at end of chain", xfer_st, 1'b1);
        chk("R7", "ch_en cleared at end of chain", ch_en, 1'b0);
        chk("R7", "no block status on terminate", blk_st, 1'b0);
        step();
        chk("R7", "no read after end", rd_valid, 1'b0);
        sw_clr_xfer = 1'b1;
        step();
        sw_clr_xfer = 1'b0;
        chk("R9", "xfer_st cleared", xfer_st, 1'b0);

        // no reload, no stall: descriptor source is taken
        sw_reload = 1'b0; sw_int_en = 1'b0; sw_blk_mask = 1'b1;
        start_xfer(32'h1234, 32'h100);
        block_end();
        chk("R6", "no blk_st when disabled", blk_st, 1'b0);
        take_five(32'h100);
        chk("R3", "word 0 loaded without reload", cur_src, 32'h5000_0001);
        block_end();
        take_five(32'h200);
        chk("R3", "second source loaded", cur_src, 32'h5000_0002);
        block_end();
        chk("R7", "xfer_st", xfer_st, 1'b1);
        chk("R7", "ch_en", ch_en, 1'b0);
        cleanup();

        // reload with zero pointer keeps repeating
        sw_reload = 1'b1; sw_int_en = 1'b0; sw_blk_mask = 1'b0;
        start_xfer(32'h77, 32'h0);
        for (int b = 0; b < 3; b++) begin
            block_end();
            chk("R8", "block repeats", mv_active, 1'b1);
            chk("R8", "no fetch", rd_valid, 1'b0);
            chk("R8", "source restored", cur_src, 32'h77);
        end
        sw_reload = 1'b0;
        block_end();
        chk("R7", "ends after reload cleared", ch_en, 1'b0);
        cleanup();

        // abort during stall
        sw_reload = 1'b1; sw_int_en = 1'b1; sw_blk_mask = 1'b1;
        start_xfer(32'h88, 32'h100);
        block_end();
        sw_disable = 1'b1;
        step();
        sw_disable = 1'b0;
        chk("R10", "ch_en after stall abort", ch_en, 1'b0);
        chk("R10", "xfer_st not set", xfer_st, 1'b0);
        chk("R10", "blk_st kept", blk_st, 1'b1);
        cleanup();

        // set wins over same-cycle clear
        start_xfer(32'h99, 32'h100);
        mv_done = 1'b1; sw_clr_blk = 1'b1;
        step();
        mv_done = 1'b0; sw_clr_blk = 1'b0;
        chk("R9", "set beats clear", blk_st, 1'b1);
        cleanup();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule